// File: doc/BRIEF.md
# Converter Output Formatter with Range Flag and Data Strobe

This block is the last digital stage of a pipelined analog-to-digital converter. Each corrected sample code enters on the rising clock edge and leaves on a bus of the same width after a fixed delay of six and a half clock cycles. The half cycle comes from a final register that is clocked on the falling edge. A format input picks the output code. When it is high the code leaves unchanged as straight offset binary. When it is low the top bit is inverted, which turns the code into two's complement.

A range flag travels with each word. It is raised when the raw code is at either end of the scale, so it does not depend on the format setting. A data strobe mirrors the clock, so its falling edge marks each new word. An active-low output enable switches all outputs to high impedance. Each tri-state pin is modelled as a drive value plus a drive enable. Sampling and the delay line keep running while the outputs float, so the first word seen after re-enabling is already the current one.

Top module: `adc_out_stage`

## Requirements
- R1: While `rst` is high, every falling clock edge clears the registered outputs, so `dq` reads 0 and `oor` reads 0.
- R2: When `fmt_bin` is 1 at the falling edge that loads a word, `dq` equals the raw sample code.
- R3: When `fmt_bin` is 0 at the falling edge that loads a word, `dq[9]` is the inverse of raw bit 9 and `dq[8:0]` equals raw bits 8:0. Raw 0, 511, 512 and 1023 become 512, 1023, 0 and 511.
- R4: `oor` is 1 exactly when the raw code is all zeros (0) or all ones (1023), whatever the value of `fmt_bin`.
- R5: `oor` and `dq` always describe the same sample.
- R6: A code present at rising edge n appears on `dq` at the falling edge half a cycle after rising edge n+6, which is 6.5 cycles later. It holds there for one full clock period.
- R7: `dq_en`, `oor_en` and `drdy_en` are all the inverse of `oe_n`. They follow `oe_n` without waiting for a clock edge.
- R8: Samples keep flowing through the pipeline while `oe_n` is high. The first word after `oe_n` returns low is the word for the sample taken 6.5 cycles earlier, not a stale one.
- R9: `drdy` carries the clock level. It is low in the half cycle after a new word is loaded, and high in the following half cycle, during which `dq` holds the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; samples are taken on the rising edge, words are launched on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_code | input | 10 | Corrected raw sample code in offset binary |
| fmt_bin | input | 1 | 1 selects straight binary, 0 selects two's complement |
| oe_n | input | 1 | Active-low output enable |
| dq | output | 10 | Output word drive value |
| dq_en | output | 1 | Drive enable for `dq` (0 means high impedance) |
| oor | output | 1 | Range flag drive value |
| oor_en | output | 1 | Drive enable for `oor` |
| drdy | output | 1 | Data strobe drive value (clock replica) |
| drdy_en | output | 1 | Drive enable for `drdy` |

## Verification
If a stage of the delay line is lost or duplicated, every word lands one cycle early or late. A stream of distinct codes therefore shows a mismatch on the first compared word. An inversion on the wrong bit, or a range test done after formatting, shows at the four corner codes within one word in each format. If the enable path or the strobe were tied to a register instead of running live, the pins would answer a full half cycle late, and the first sample after the change exposes it.

// File: rtl/adc_out_pkg.sv
`timescale 1ns/1ps
package adc_out_pkg;

  // Output code selection; the encoding matches the fmt_bin pin level
  typedef enum logic {
    FMT_TWOS = 1'b0,
    FMT_BIN  = 1'b1
  } fmt_e;

endpackage

// File: rtl/adc_out_delay.sv
`timescale 1ns/1ps
module adc_out_delay #(
  parameter int W      = 10,
  parameter int STAGES = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= din;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/adc_out_format.sv
`timescale 1ns/1ps
module adc_out_format
  import adc_out_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] raw,
  input  fmt_e         fmt,
  output logic [W-1:0] word,
  output logic         at_limit
);

  // Range test on the raw code so the format setting cannot alter it
  always_comb begin
    at_limit = (raw == '0) || (raw == '1);
    word     = raw;
    if (fmt == FMT_TWOS) word[W-1] = ~raw[W-1];
  end

endmodule

// File: rtl/adc_out_launch.sv
`timescale 1ns/1ps
module adc_out_launch #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word_d,
  input  logic         flag_d,
  output logic [W-1:0] word_q,
  output logic         flag_q
);

  // Falling-edge stage: supplies the half cycle of the total latency
  always_ff @(negedge clk) begin
    if (rst) begin
      word_q <= '0;
      flag_q <= 1'b0;
    end else begin
      word_q <= word_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/adc_out_stage.sv
`timescale 1ns/1ps
module adc_out_stage
  import adc_out_pkg::*;
#(
  parameter int W           = 10,
  parameter int PIPE_CYCLES = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp_code,
  input  logic         fmt_bin,
  input  logic         oe_n,
  output logic [W-1:0] dq,
  output logic         dq_en,
  output logic         oor,
  output logic         oor_en,
  output logic         drdy,
  output logic         drdy_en
);

  // One capture register plus PIPE_CYCLES whole-cycle delays
  localparam int STAGES = PIPE_CYCLES + 1;

  logic [W-1:0] raw_late;
  logic [W-1:0] word_fmt;
  logic         limit_hit;
  logic         drive_on;

  adc_out_delay #(.W(W), .STAGES(STAGES)) delay_i (
    .clk  (clk),
    .rst  (rst),
    .din  (smp_code),
    .dout (raw_late)
  );

  adc_out_format #(.W(W)) format_i (
    .raw      (raw_late),
    .fmt      (fmt_e'(fmt_bin)),
    .word     (word_fmt),
    .at_limit (limit_hit)
  );

  adc_out_launch #(.W(W)) launch_i (
    .clk    (clk),
    .rst    (rst),
    .word_d (word_fmt),
    .flag_d (limit_hit),
    .word_q (dq),
    .flag_q (oor)
  );

  // Enables act at once, without a register; the strobe mirrors the clock
  assign drive_on = ~oe_n;
  assign dq_en    = drive_on;
  assign oor_en   = drive_on;
  assign drdy_en  = drive_on;
  assign drdy     = clk;

endmodule

// File: rtl/adc_out_stage_chk.sv
`timescale 1ns/1ps
module adc_out_stage_chk #(
  parameter int W           = 10,
  parameter int PIPE_CYCLES = 6
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] smp_code,
  input logic         fmt_bin,
  input logic         oe_n,
  input logic [W-1:0] dq,
  input logic         dq_en,
  input logic         oor,
  input logic         oor_en,
  input logic         drdy_en
);

  logic [W-1:0] hist [PIPE_CYCLES+1];
  logic         rst_at_fall;

  always_ff @(posedge clk) begin
    for (int i = 0; i <= PIPE_CYCLES; i++) begin
      if (rst)         hist[i] <= '0;
      else if (i == 0) hist[i] <= smp_code;
      else             hist[i] <= hist[i-1];
    end
  end

  always_ff @(negedge clk) rst_at_fall <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst && rst_at_fall) begin
      rst_clear_chk: assert (dq == '0 && !oor);
    end
  end

  // R6
  low_bits_lat_chk: assert property (@(posedge clk) disable iff (rst)
    dq[W-2:0] == hist[PIPE_CYCLES][W-2:0]);

  // R4 R5
  oor_same_sample_chk: assert property (@(posedge clk) disable iff (rst)
    oor == ((hist[PIPE_CYCLES] == '0) || (hist[PIPE_CYCLES] == '1)));

  // R2
  bin_msb_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(fmt_bin) && fmt_bin) |-> (dq[W-1] == hist[PIPE_CYCLES][W-1]));

  // R3
  twos_msb_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(fmt_bin) && !fmt_bin) |-> (dq[W-1] != hist[PIPE_CYCLES][W-1]));

  // R7
  drive_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (dq_en != oe_n) && (oor_en != oe_n) && (drdy_en != oe_n));

endmodule

bind adc_out_stage adc_out_stage_chk #(.W(W), .PIPE_CYCLES(PIPE_CYCLES)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .smp_code (smp_code),
  .fmt_bin  (fmt_bin),
  .oe_n     (oe_n),
  .dq       (dq),
  .dq_en    (dq_en),
  .oor      (oor),
  .oor_en   (oor_en),
  .drdy_en  (drdy_en)
);

// File: tb/adc_out_stage_tb.sv
`timescale 1ns/1ps
module adc_out_stage_tb_top;

  localparam real CLK_P = 10.0;
  localparam int  W     = 10;
  localparam int  FILL  = 8;   // queued items when the oldest is due

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] smp_code = '0;
  logic         fmt_bin = 1'b1;
  logic         oe_n = 1'b0;
  logic [W-1:0] dq;
  logic         dq_en, oor, oor_en, drdy, drdy_en;

  int           n_chk = 0;
  int           n_bad = 0;
  bit           active = 1'b0;
  bit           done = 1'b0;
  logic [W-1:0] held_dq;
  logic [W-1:0] sb_q [$];

  always #(CLK_P/2) clk = ~clk;

  adc_out_stage #(.W(W), .PIPE_CYCLES(6)) dut_i (
    .clk(clk), .rst(rst), .smp_code(smp_code), .fmt_bin(fmt_bin), .oe_n(oe_n),
    .dq(dq), .dq_en(dq_en), .oor(oor), .oor_en(oor_en),
    .drdy(drdy), .drdy_en(drdy_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: apply one code and push it into the scoreboard
  task automatic drive(input logic [W-1:0] c);
    @(negedge clk);
    smp_code = c;
    sb_q.push_back(c);
  endtask

  task automatic set_fmt(input logic f);
    @(posedge clk); #1 fmt_bin = f;
  endtask

  task automatic corners();
    drive(10'd0); drive(10'd511); drive(10'd512); drive(10'd1023);
  endtask

  // Monitor on the falling edge: the oldest item is due when the queue is full
  initial forever begin
    @(negedge clk); #2;
    held_dq = dq;
    if (active && sb_q.size() == FILL) begin
      logic [W-1:0] raw, exp_dq;
      logic exp_oor;
      raw     = sb_q.pop_front();
      exp_dq  = fmt_bin ? raw : (raw ^ 10'h200);
      exp_oor = (raw == 10'd0) || (raw == 10'd1023);
      if (oe_n) begin
        check(!dq_en && !oor_en && !drdy_en, "R7 R8 floating while disabled",
              {dq_en, oor_en, drdy_en}, 0);
      end else begin
        check(dq_en && oor_en && drdy_en, "R7 driven while enabled",
              {dq_en, oor_en, drdy_en}, 7);
        check(dq == exp_dq, fmt_bin ? "R2 R6 R8 binary word" : "R3 R6 R8 twos word",
              dq, exp_dq);
        check(oor == exp_oor, "R4 R5 range flag", oor, exp_oor);
        check(drdy == 1'b0, "R9 strobe low after launch", drdy, 0);
      end
    end
  end

  // Second half of each cycle: strobe high, word unchanged
  initial forever begin
    @(posedge clk); #2;
    if (active && !oe_n && sb_q.size() == FILL - 1) begin
      check(drdy == 1'b1, "R9 strobe high", drdy, 1);
      check(dq == held_dq, "R6 R9 word held", dq, held_dq);
    end
  end

  initial begin
    #(CLK_P * 200000.0);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(dq == '0, "R1 reset word", dq, 0);
    check(oor == 1'b0, "R1 reset flag", oor, 0);
    check(dq_en == 1'b1, "R7 enable during reset", dq_en, 1);
    @(posedge clk); #1 rst = 1'b0;
    active = 1'b1;

    // Straight binary: corners and a spread of codes
    corners();
    for (int i = 0; i < 40; i++) drive(10'((i * 97 + 13) % 1024));
    corners();

    // Two's complement
    set_fmt(1'b0);
    corners();
    for (int i = 0; i < 40; i++) drive(10'((i * 211 + 5) % 1024));
    corners();

    // Outputs floating while sampling continues (R8)
    @(posedge clk); #1 oe_n = 1'b1;
    #1 check(!dq_en && !oor_en && !drdy_en, "R7 immediate float", dq_en, 0);
    for (int i = 0; i < 12; i++) drive(10'((i * 61 + 300) % 1024));
    @(posedge clk); #1 oe_n = 1'b0;
    #1 check(dq_en && oor_en && drdy_en, "R7 immediate drive", dq_en, 1);
    corners();
    for (int i = 0; i < 10; i++) drive(10'(i * 3 + 700));

    // Back to binary, then flush the scoreboard
    set_fmt(1'b1);
    corners();
    for (int i = 0; i < FILL; i++) drive(10'(i + 100));
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule